// File: doc/BRIEF.md
# Factored Up-Down Bounce Counter

This block produces a count that climbs from zero to its largest value, then steps back down to zero, and repeats for as long as it is clocked. With the default two-bit width the output runs through the six values 00, 01, 10, 11, 10, 01 and then starts again. The output is taken straight from the counter's state, with no decoding stage after it.

The design is split into parts. A general up/down counter core is driven by a two-wire mode control, with one code each for hold, count up, clear to zero and count down. A single direction flip-flop records whether the sequence is rising or falling. A few gates turn the direction bit and an initialise request into the core's two mode wires. The core has no reset of its own. Initialisation works by presenting the clear code to the core while the direction flop is cleared at the same edge.

To use the block, hold `init` high for at least one clock to force the count to zero with the direction set to rising. After `init` is released the sequence runs freely.

Top module: `bounce_counter`

## Requirements
- R1: A clock edge with `init` high leaves `count` at zero after that edge, whatever the count and direction were before.
- R2: After `init` is released, the values of `count` after the following edges are 1, 2, 3, 2, 1, 0, and this six-edge period then repeats with no end (default width W=2, so the peak is 3).
- R3: While `init` stays low, every edge changes `count` by exactly one, up or down. It never holds its value and never jumps.
- R4: While `init` is low, an edge at which `count` equals the peak value (all ones) is followed by the value one below the peak.
- R5: While `init` is low, an edge at which `count` is zero after a descent is followed by the value 1, so the sequence turns upward again.
- R6: Asserting `init` partway through a descent restarts the sequence at zero, and the next free-running edge gives 1. This means the direction is rising again.
- R7: Holding `init` high for several edges keeps `count` at zero on every one of them.
- R8: The direction state is falling whenever `count` equals the peak value during free running. It is rising whenever `count` is zero after the first free-running edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| init | input | 1 | Synchronous initialise: clears the count and sets the direction to rising |
| count | output | W | Current count, taken directly from the counter state |

## Verification
The assertions assume that `init` has been high for at least one edge before any sequence property is judged. This is needed because the core has no reset, so its value before initialisation is arbitrary. They also stop judging the cycle right after `init` falls, because that cycle shows the zero forced by the clear rather than a step. The stimulus always starts with an initialise pulse, changes `init` only away from the rising edge, and re-initialises at a peak, in the middle of a descent and over several held cycles, so every turn and restart case happens inside the window the properties cover.

// File: rtl/bounce_pkg.sv
package bounce_pkg;
   // Mode code presented to the up/down core as {a, b}
   typedef enum logic [1:0] {
      MODE_HOLD = 2'b00,
      MODE_UP   = 2'b01,
      MODE_CLR  = 2'b10,
      MODE_DOWN = 2'b11
   } mode_e;

   typedef enum logic {
      DIR_RISE = 1'b0,
      DIR_FALL = 1'b1
   } dir_e;
endpackage

// File: rtl/updn_core.sv
module updn_core
   import bounce_pkg::*;
#(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         ctl_a,
   input  logic         ctl_b,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] ONE = W'(1);

   mode_e         mode;
   logic [W-1:0]  cnt_q;
   logic [W-1:0]  cnt_d;

   assign mode = mode_e'({ctl_a, ctl_b});

   always_comb begin
      unique case (mode)
         MODE_HOLD: cnt_d = cnt_q;
         MODE_UP:   cnt_d = cnt_q + ONE;
         MODE_CLR:  cnt_d = '0;
         MODE_DOWN: cnt_d = cnt_q - ONE;
         default:   cnt_d = cnt_q;
      endcase
   end

   // State flops with no reset: clearing happens through the mode code
   always_ff @(posedge clk) begin
      cnt_q <= cnt_d;
   end

   assign cnt = cnt_q;
endmodule

// File: rtl/bounce_dir.sv
module bounce_dir
   import bounce_pkg::*;
#(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         init,
   input  logic [W-1:0] cnt,
   output dir_e         dir
);
   localparam logic [W-1:0] PEAK      = {W{1'b1}};
   localparam logic [W-1:0] PRE_PEAK  = PEAK - W'(1);
   localparam logic [W-1:0] PRE_FLOOR = W'(1);

   dir_e dir_q;
   dir_e dir_d;

   always_comb begin
      dir_d = dir_q;
      if (init)
         dir_d = DIR_RISE;
      else if (dir_q == DIR_RISE && cnt == PRE_PEAK)
         dir_d = DIR_FALL;
      else if (dir_q == DIR_FALL && cnt == PRE_FLOOR)
         dir_d = DIR_RISE;
   end

   always_ff @(posedge clk) begin
      dir_q <= dir_d;
   end

   assign dir = dir_q;
endmodule

// File: rtl/bounce_steer.sv
module bounce_steer
   import bounce_pkg::*;
(
   input  logic init,
   input  dir_e dir,
   output logic ctl_a,
   output logic ctl_b
);
   // init -> clear (1,0); rising -> up (0,1); falling -> down (1,1)
   assign ctl_a = init | (dir == DIR_FALL);
   assign ctl_b = ~init;
endmodule

// File: rtl/bounce_counter.sv
module bounce_counter
   import bounce_pkg::*;
#(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         init,
   output logic [W-1:0] count
);
   generate
      if (W < 2) begin : g_bad_width
         $error("bounce_counter: W must be at least 2");
      end
   endgenerate

   logic ctl_a;
   logic ctl_b;
   dir_e dir_q;

   updn_core #(.W(W)) u_core (
      .clk   (clk),
      .ctl_a (ctl_a),
      .ctl_b (ctl_b),
      .cnt   (count)
   );

   bounce_dir #(.W(W)) u_dir (
      .clk  (clk),
      .init (init),
      .cnt  (count),
      .dir  (dir_q)
   );

   bounce_steer u_steer (
      .init  (init),
      .dir   (dir_q),
      .ctl_a (ctl_a),
      .ctl_b (ctl_b)
   );
endmodule

// File: rtl/bounce_counter_chk.sv
module bounce_counter_chk
   import bounce_pkg::*;
#(
   parameter int W = 2
) (
   input logic         clk,
   input logic         init,
   input logic [W-1:0] count,
   input dir_e         dir
);
   localparam logic [W-1:0] PEAK = {W{1'b1}};
   localparam logic [W-1:0] ONE  = W'(1);

   logic seen_init = 1'b0;
   logic init_prev = 1'b1;
   logic live;

   always_ff @(posedge clk) begin
      if (init) seen_init <= 1'b1;
      init_prev <= init;
   end

   assign live = seen_init && !init_prev && !init;

   AST_INIT_CLEARS: assert property (@(posedge clk)
      init |=> (count == '0)) else $error("init did not clear");          // R1

   AST_INIT_HELD: assert property (@(posedge clk)
      (init && $past(init)) |-> (count == '0)) else $error("held init");  // R7

   AST_UNIT_STEP: assert property (@(posedge clk) disable iff (init)
      live |-> (count == $past(count) + ONE || count == $past(count) - ONE))
      else $error("step not unit");                                       // R3

   AST_PEAK_TURN: assert property (@(posedge clk) disable iff (init)
      (live && count == PEAK) |=> (count == PEAK - ONE))
      else $error("no turn at peak");                                     // R4

   AST_FLOOR_TURN: assert property (@(posedge clk) disable iff (init)
      (live && count == '0) |=> (count == ONE))
      else $error("no turn at floor");                                    // R5

   AST_DIR_AT_PEAK: assert property (@(posedge clk) disable iff (init)
      (live && count == PEAK) |-> (dir == DIR_FALL))
      else $error("direction wrong at peak");                             // R8

   AST_DIR_AT_FLOOR: assert property (@(posedge clk) disable iff (init)
      (live && count == '0) |-> (dir == DIR_RISE))
      else $error("direction wrong at floor");                            // R8
endmodule

bind bounce_counter bounce_counter_chk #(.W(W)) u_chk (
   .clk   (clk),
   .init  (init),
   .count (count),
   .dir   (dir_q)
);

// File: tb/bounce_counter_bench.sv
module bounce_counter_bench;
   localparam int W    = 2;
   localparam int PEAK = (1 << W) - 1;
   localparam int PER  = 2 * PEAK;

   logic         clk = 1'b0;
   logic         init = 1'b0;
   logic [W-1:0] count;
   int           n_chk = 0;
   int           n_fail = 0;
   bit           done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   bounce_counter #(.W(W)) u_bounce_counter (
      .clk   (clk),
      .init  (init),
      .count (count)
   );

   // Expected value k free-running edges after the init edge
   function automatic int tri_val(input int k);
      int m;
      m = k % PER;
      return (m <= PEAK) ? m : PER - m;
   endfunction

   task automatic check(input int exp, input string req);
      n_chk++;
      if (int'(count) != exp) begin
         n_fail++;
         $display("FAIL %s: count=%0d expected=%0d at %0t", req, count, exp, $time);
      end
   endtask

   // One init edge, released just after it
   task automatic do_init();
      init = 1'b1;
      @(posedge clk); #1;
      check(0, "R1");
      init = 1'b0;
   endtask

   task automatic run_steps(input int from_k, input int n, input string req);
      for (int i = 1; i <= n; i++) begin
         int prev;
         prev = int'(count);
         @(posedge clk); #1;
         check(tri_val(from_k + i), req);
         n_chk++;
         if (!(int'(count) == prev + 1 || int'(count) == prev - 1)) begin
            n_fail++;
            $display("FAIL R3: count=%0d expected=%0d+-1", count, prev);
         end
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      do_init();
   endtask

   task automatic t_three_periods();
      do_init();
      run_steps(0, 3 * PER, "R2");
   endtask

   task automatic t_turns();
      do_init();
      run_steps(0, PEAK, "R2");       // at peak
      @(posedge clk); #1; check(PEAK - 1, "R4");
      run_steps(PEAK + 1, PEAK - 1, "R2"); // down to zero
      @(posedge clk); #1; check(1, "R5");
   endtask

   task automatic t_init_mid_descent();
      do_init();
      run_steps(0, PEAK + 1, "R2");   // count = PEAK-1, descending
      do_init();
      check(0, "R6");
      @(posedge clk); #1; check(1, "R6");
      @(posedge clk); #1; check(2, "R6");
   endtask

   task automatic t_init_at_peak();
      do_init();
      run_steps(0, PEAK, "R2");
      do_init();
      @(posedge clk); #1; check(1, "R6");
   endtask

   task automatic t_init_held();
      init = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(posedge clk); #1;
         check(0, "R7");
      end
      init = 1'b0;
      @(posedge clk); #1; check(1, "R7");
   endtask

   initial begin
      t_reset();
      t_three_periods();
      t_turns();
      t_init_mid_descent();
      t_init_at_peak();
      t_init_held();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule